// File: doc/BRIEF.md
# Reset Vector Fetch Unit

This unit runs once each time the processor leaves reset. It decides which of six vector locations holds the start address and reads that address as two bytes over a byte-wide memory bus. It then hands the assembled 16-bit value to the core as its initial program counter and raises a run-enable that lets the core start fetching instructions.

The vector location depends on two things: the cause of the reset and the operating mode. There are three causes: power-on or external pin, clock-monitor failure, and watchdog timeout. The mode is either normal or test/boot, and the test/boot mode moves the vector group to a lower page. The unit also drives the initial state of the two interrupt mask bits of the condition code register.

The memory is synchronous. Read data for an address and strobe presented in one cycle is valid during the next cycle. The fetch follows the states `ST_LATCH → ST_RD_HI → ST_RD_LO → ST_CAP_LO → ST_RUN`, and `ST_RUN` holds until the next reset. The transitions are:
- latch-to-read-high: capture the cause and mode.
- high-to-low: present the odd address and capture the high byte.
- low-to-capture: capture the low byte.
- capture-to-run: assert run-enable.

Top module: `rstvec_loader`

## Requirements
- R1: In normal mode (`mode_alt`=0), a power-on/pin reset fetches the high byte from 0xFFFE and the low byte from 0xFFFF.
- R2: In normal mode, a clock-monitor reset fetches from 0xFFFC/0xFFFD, and a watchdog reset fetches from 0xFFFA/0xFFFB.
- R3: In test/boot mode (`mode_alt`=1), the three causes fetch from 0xBFFE, 0xBFFC and 0xBFFA (each with its following odd address).
- R4: When several cause flags are set, power-on/pin wins over clock monitor, and clock monitor wins over watchdog. When no flag is set, the power-on/pin vector is used.
- R5: `pc_init` equals {byte read at the even address, byte read at the odd address}.
- R6: `bus_rd` is high for exactly two cycles. It presents the even address in the 2nd cycle after reset release and the odd address in the 3rd. It is low at all other times.
- R7: `run_en` rises after the 4th rising edge following reset release, only once `pc_init` holds both bytes. It then stays high, with `pc_init` stable, until reset.
- R8: `mask_i` and `mask_x` are 1 during and after reset.
- R9: Cause flags and `mode_alt` are sampled only on the first edge after reset release. Later changes have no effect on the address or on `pc_init`.
- R10: While `rst_n` is low, `bus_rd` and `run_en` are 0. A reset during the fetch restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_por | input | 1 | Power-on or pin reset flag |
| cause_cmon | input | 1 | Clock-monitor reset flag |
| cause_wdog | input | 1 | Watchdog reset flag |
| mode_alt | input | 1 | 1 selects the test/boot vector page |
| bus_rdata | input | 8 | Memory read data, valid one cycle after strobe |
| bus_addr | output | 16 | Memory address |
| bus_rd | output | 1 | Memory read strobe |
| pc_init | output | 16 | Assembled initial program counter |
| mask_i | output | 1 | Initial maskable-interrupt mask bit |
| mask_x | output | 1 | Initial non-maskable-pin interrupt mask bit |
| run_en | output | 1 | Core may start executing |

## Verification
A wrong state register becomes visible at the ports within one cycle. A skipped or repeated state moves the strobe window or the odd address by a cycle, or makes run-enable rise early or late. A wrong selector or a late sample of the cause shows up in the first read cycle as a wrong `bus_addr`. A swapped byte capture shows up only once run-enable is high, as a byte-reversed `pc_init`. Each case is therefore checked on the exact cycle, and the memory model returns a different, address-dependent byte at each location.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;
    typedef enum logic [2:0] {
        ST_LATCH  = 3'd0,
        ST_RD_HI  = 3'd1,
        ST_RD_LO  = 3'd2,
        ST_CAP_LO = 3'd3,
        ST_RUN    = 3'd4
    } fetch_state_t;

    // Index doubles as the word offset below the page top.
    typedef enum logic [1:0] {
        SRC_POR  = 2'd0,
        SRC_CMON = 2'd1,
        SRC_WDOG = 2'd2
    } reset_src_t;

    localparam int unsigned N_CAUSES = 3;
endpackage

// File: rtl/rstvec_select.sv
module rstvec_select
    import rstvec_pkg::*;
#(
    parameter int unsigned           ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]     TOP_NORM = 16'hFFFE,
    parameter logic [ADDR_W-1:0]     TOP_ALT  = 16'hBFFE
) (
    input  logic [N_CAUSES-1:0] cause_vec,   // [0]=por [1]=cmon [2]=wdog
    input  logic                mode_alt,
    output logic [ADDR_W-1:0]   vec_base
);
    reset_src_t          src;
    logic [ADDR_W-1:0]   page_top;
    logic [ADDR_W-1:0]   offs;

    // Lowest index wins: walk from lowest priority upward.
    always_comb begin
        src = SRC_POR;
        for (int i = N_CAUSES - 1; i >= 0; i--) begin
            if (cause_vec[i]) src = reset_src_t'(i);
        end
    end

    assign page_top = mode_alt ? TOP_ALT : TOP_NORM;
    assign offs     = ADDR_W'({src, 1'b0});
    assign vec_base = page_top - offs;
endmodule

// File: rtl/rstvec_fsm.sv
module rstvec_fsm
    import rstvec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic ld_base,
    output logic rd_strobe,
    output logic sel_odd,
    output logic cap_hi,
    output logic cap_lo,
    output logic run
);
    fetch_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LATCH;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_LATCH:  state_nx = ST_RD_HI;
            ST_RD_HI:  state_nx = ST_RD_LO;
            ST_RD_LO:  state_nx = ST_CAP_LO;
            ST_CAP_LO: state_nx = ST_RUN;
            ST_RUN:    state_nx = ST_RUN;
            default:   state_nx = ST_LATCH;
        endcase
    end

    always_comb begin
        ld_base   = 1'b0;
        rd_strobe = 1'b0;
        sel_odd   = 1'b0;
        cap_hi    = 1'b0;
        cap_lo    = 1'b0;
        run       = 1'b0;
        unique case (state)
            ST_LATCH:  ld_base = 1'b1;
            ST_RD_HI:  rd_strobe = 1'b1;
            ST_RD_LO:  begin rd_strobe = 1'b1; sel_odd = 1'b1; cap_hi = 1'b1; end
            ST_CAP_LO: cap_lo = 1'b1;
            ST_RUN:    run = 1'b1;
            default:   ;
        endcase
    end

    // R6: the high read is always followed by the low read.
    a_r6_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_HI) |=> (state == ST_RD_LO));
    // R7: the run state is absorbing.
    a_r7_run_absorbing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN));
endmodule

// File: rtl/rstvec_pcreg.sv
module rstvec_pcreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic              cap_lo,
    input  logic [DATA_W-1:0] rdata,
    output logic [2*DATA_W-1:0] pc
);
    logic [DATA_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi) hi_q <= rdata;
            if (cap_lo) lo_q <= rdata;
        end
    end

    assign pc = {hi_q, lo_q};
endmodule

// File: rtl/rstvec_loader.sv
module rstvec_loader
    import rstvec_pkg::*;
#(
    parameter int unsigned        DATA_W   = 8,
    parameter int unsigned        ADDR_W   = 2 * DATA_W,
    parameter logic [ADDR_W-1:0]  TOP_NORM = 16'hFFFE,
    parameter logic [ADDR_W-1:0]  TOP_ALT  = 16'hBFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_por,
    input  logic              cause_cmon,
    input  logic              cause_wdog,
    input  logic              mode_alt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] pc_init,
    output logic              mask_i,
    output logic              mask_x,
    output logic              run_en
);
    logic                ld_base, rd_strobe, sel_odd, cap_hi, cap_lo, run;
    logic [ADDR_W-1:0]   vec_sel, base_q;
    logic                mask_i_q, mask_x_q;

    rstvec_select #(.ADDR_W(ADDR_W), .TOP_NORM(TOP_NORM), .TOP_ALT(TOP_ALT)) u_sel (
        .cause_vec ({cause_wdog, cause_cmon, cause_por}),
        .mode_alt  (mode_alt),
        .vec_base  (vec_sel)
    );

    rstvec_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_base   (ld_base),
        .rd_strobe (rd_strobe),
        .sel_odd   (sel_odd),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .run       (run)
    );

    rstvec_pcreg #(.DATA_W(DATA_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .rdata  (bus_rdata),
        .pc     (pc_init)
    );

    // R9: the selection is frozen on the first edge after release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       base_q <= TOP_NORM;
        else if (ld_base) base_q <= vec_sel;
    end

    // R8: both masks come out of reset set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_i_q <= 1'b1;
            mask_x_q <= 1'b1;
        end else begin
            mask_i_q <= mask_i_q;
            mask_x_q <= mask_x_q;
        end
    end

    assign bus_addr = {base_q[ADDR_W-1:1], sel_odd};
    assign bus_rd   = rd_strobe;
    assign run_en   = run;
    assign mask_i   = mask_i_q;
    assign mask_x   = mask_x_q;

    // R6: the strobe never overlaps run-enable.
    a_r6_rd_not_run: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !run_en);
    // R6/R9: the second read uses the odd partner of the first address.
    a_r9_odd_follows_even: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(bus_rd)) |-> (bus_addr == ($past(bus_addr) | 16'h0001)));
    // R7: run-enable rises one idle cycle after two reads.
    a_r7_run_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> (!$past(bus_rd) && $past(bus_rd, 2)));
    // R7: run-enable sticks and the PC holds.
    a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (run_en && $stable(pc_init)));
endmodule

// File: tb/rstvec_loader_test.sv
module rstvec_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cause_por = 1'b0, cause_cmon = 1'b0, cause_wdog = 1'b0, mode_alt = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic [15:0] bus_addr, pc_init;
    logic        bus_rd, mask_i, mask_x, run_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstvec_loader uut (
        .clk(clk), .rst_n(rst_n),
        .cause_por(cause_por), .cause_cmon(cause_cmon), .cause_wdog(cause_wdog),
        .mode_alt(mode_alt), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .pc_init(pc_init),
        .mask_i(mask_i), .mask_x(mask_x), .run_en(run_en)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) if (bus_rd) bus_rdata <= mem_byte(bus_addr);

    // {mode_alt, por, cmon, wdog, expected even address}
    localparam logic [19:0] VEC_TAB [10] = '{
        {4'b0100, 16'hFFFE},   // R1 power-on normal
        {4'b0010, 16'hFFFC},   // R2 clock monitor
        {4'b0001, 16'hFFFA},   // R2 watchdog
        {4'b0111, 16'hFFFE},   // R4 all flags
        {4'b0011, 16'hFFFC},   // R4 cmon over wdog
        {4'b0000, 16'hFFFE},   // R4 no flag
        {4'b1100, 16'hBFFE},   // R3 power-on alt
        {4'b1010, 16'hBFFC},   // R3 cmon alt
        {4'b1001, 16'hBFFA},   // R3 wdog alt
        {4'b1011, 16'hBFFC}    // R3/R4 priority alt
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [3:0] f);
        rst_n = 1'b0;
        {mode_alt, cause_por, cause_cmon, cause_wdog} = f;
        tick();
        rst_n = 1'b1;
    endtask

    task automatic run_fetch(input logic [15:0] base, input string tag);
        tick();
        chk({tag, " R6 rd hi"}, bus_rd, 1);
        chk({tag, " even addr"}, bus_addr, base);
        tick();
        chk({tag, " R6 rd lo"}, bus_rd, 1);
        chk({tag, " odd addr"}, bus_addr, base | 16'h1);
        tick();
        chk({tag, " R7 early run"}, {bus_rd, run_en}, 2'b00);
        tick();
        chk({tag, " R7 run"}, run_en, 1);
        chk({tag, " R5 pc"}, pc_init, {mem_byte(base), mem_byte(base | 16'h1)});
        chk({tag, " R8 masks"}, {mask_i, mask_x}, 2'b11);
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10 / R8 reset state
        chk("R10 reset outputs", {bus_rd, run_en}, 2'b00);
        chk("R8 reset masks", {mask_i, mask_x}, 2'b11);

        for (int k = 0; k < 10; k++) begin
            start(VEC_TAB[k][19:16]);
            run_fetch(VEC_TAB[k][15:0], "R1/R2/R3/R4 table");
            tick();
            chk("R7 stays run", {run_en, bus_rd}, 2'b10);
        end

        // R9: flags change after sampling edge
        start(4'b0010);
        tick();
        {mode_alt, cause_por, cause_cmon, cause_wdog} = 4'b1100;
        chk("R9 addr frozen", bus_addr, 16'hFFFC);
        tick();
        chk("R9 odd frozen", bus_addr, 16'hFFFD);
        tick();
        tick();
        chk("R9 pc", pc_init, {mem_byte(16'hFFFC), mem_byte(16'hFFFD)});

        // R10: reset mid-fetch restarts
        start(4'b0001);
        tick();
        tick();
        rst_n = 1'b0;
        #1;
        chk("R10 abort", {bus_rd, run_en}, 2'b00);
        start(4'b1010);
        run_fetch(16'hBFFC, "R10 restart");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule